// File: doc/BRIEF.md
# Pointer-Indexed Stream FIFO

This block is a single-clock first-in first-out buffer with stream handshakes on both sides. Each beat is a data word together with an end-of-packet flag. Words are held in a simple dual-port RAM. Two binary pointers address it, and each pointer carries one extra wrap bit. The RAM has a registered read port, and its output runs through a chain of output registers that is set by a parameter. Every register in that chain has its own valid flag and passes ready back toward the RAM.

The input side is ready only when the two pointers say there is room. The state of the output chain plays no part in that decision. While the FIFO is empty the RAM is still read on every cycle in which the chain can take a word, but the result is marked invalid. A word written into an empty FIFO is only fetched on the next cycle, after the registered write pointer has moved. For this reason the read side never relies on how the memory resolves a read and a write to the same address in one cycle. The total number of beats the block can hold is the RAM depth plus one RAM output register plus the output registers.

Top module: `ptr_axis_fifo`

## Requirements
- R1: After reset both pointers are equal: `s_tready` is 1 and `m_tvalid` is 0.
- R2: A beat moves on either side only at a clock edge where valid and ready are both 1. An output beat that is offered while `m_tready` is 0 is not consumed.
- R3: Beats leave in the order they were accepted, with no loss and no duplication, under any pattern of `s_tvalid` and `m_tready`.
- R4: `s_tready` depends only on the pointers. With `m_tready` held at 0, exactly 2^ADDR_W + OUT_REGS + 1 beats are accepted before `s_tready` stays 0.
- R5: While the pointers show full, the write pointer does not move. Beats offered while `s_tready` is 0 are never delivered.
- R6: A beat accepted into an empty FIFO at clock edge t first shows `m_tvalid` = 1 after edge t + OUT_REGS + 1.
- R7: With `m_tready` held at 1 and no new input, stored beats come out on consecutive cycles with no gap, until the FIFO is empty.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle still shows `m_tvalid` = 1 with the same `m_tdata` and `m_tlast`.
- R9: `m_tlast` always belongs to the same beat as `m_tdata`, as it was accepted on `s_tlast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W | Input word |
| s_tlast | input | 1 | Input end-of-packet flag |
| s_tvalid | input | 1 | Input beat offered |
| s_tready | output | 1 | Room in the RAM (pointer comparison) |
| m_tdata | output | DATA_W | Output word |
| m_tlast | output | 1 | Output end-of-packet flag |
| m_tvalid | output | 1 | Output beat offered |
| m_tready | input | 1 | Output beat taken |

## Verification
The assertions check on every cycle that the fill level read from the pointers never exceeds the RAM depth, and that the write pointer stays put while the pointers show full. They also check that `s_tready` changes only when a pointer has moved, and that a stalled output beat is held unchanged. Some behaviours can only be shown by the bench's scenarios: the exact latency from an empty FIFO, the total capacity with the output stalled, the gap-free drain, and end-to-end ordering of data and last flags under random handshakes. The bench compares these against its queue model on every cycle.

// File: rtl/psf_pkg.sv
package psf_pkg;

    localparam int unsigned MIN_OUT_REGS = 1;

    function automatic int unsigned psf_capacity(input int unsigned addr_w,
                                                 input int unsigned out_regs);
        return (32'd1 << addr_w) + out_regs + 1;
    endfunction

endpackage

// File: rtl/psf_ram.sv
module psf_ram #(
    parameter int WIDTH  = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_data_q;

    // Write and registered read; the read side never uses data fetched
    // from the address being written in the same cycle.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
        if (rd_en)
            rd_data_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/psf_ptr_ctrl.sv
module psf_ptr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_take,
    output logic              push_ok,
    output logic              push_fire,
    output logic              pop_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1 << ADDR_W);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       full, empty;

    always_comb begin
        st_d      = st_q;
        full      = (st_q.wr[ADDR_W] != st_q.rd[ADDR_W]) &&
                    (st_q.wr[ADDR_W-1:0] == st_q.rd[ADDR_W-1:0]);
        empty     = (st_q.wr == st_q.rd);
        push_ok   = !full;
        push_fire = push_req && !full;
        pop_fire  = pop_take && !empty;
        st_d.wr   = st_q.wr + PTR_W'(push_fire);
        st_d.rd   = st_q.rd + PTR_W'(pop_fire);
        wr_addr   = st_q.wr[ADDR_W-1:0];
        rd_addr   = st_q.rd[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic [PTR_W-1:0] fill_lvl;
    assign fill_lvl = st_q.wr - st_q.rd;

    // R4: the RAM never holds more than its depth
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= DEPTH);

    // R5: a full RAM keeps the write pointer where it is
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == DEPTH) |=> $stable(st_q.wr));
endmodule

// File: rtl/psf_out_pipe.sv
module psf_out_pipe #(
    parameter int WIDTH    = 9,
    parameter int OUT_REGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_fire,
    input  logic [WIDTH-1:0] head_data,
    output logic             head_take,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ready
);
    localparam int N = OUT_REGS;

    // Stage 0 is the RAM read register (valid flag only here);
    // stages 1..N carry data.
    typedef struct packed {
        logic [N:0]            vld;
        logic [N:1][WIDTH-1:0] dat;
    } pipe_state_t;

    pipe_state_t           ps_d, ps_q;
    logic [N:0]            take;
    logic [N:0][WIDTH-1:0] src;

    always_comb begin
        take[N] = !ps_q.vld[N] || out_ready;
        for (int i = N - 1; i >= 0; i--)
            take[i] = !ps_q.vld[i] || take[i+1];

        src[0] = head_data;
        for (int i = 1; i <= N; i++)
            src[i] = ps_q.dat[i];

        ps_d = ps_q;
        if (take[0])
            ps_d.vld[0] = head_fire;
        for (int i = 1; i <= N; i++) begin
            if (take[i]) begin
                ps_d.vld[i] = ps_q.vld[i-1];
                ps_d.dat[i] = src[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_q <= '0;
        else
            ps_q <= ps_d;
    end

    assign head_take = take[0];
    assign out_valid = ps_q.vld[N];
    assign out_data  = ps_q.dat[N];

    // R8: a stalled beat is held unchanged
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ptr_axis_fifo.sv
module ptr_axis_fifo #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int OUT_REGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    import psf_pkg::*;

    localparam int LANE_W = DATA_W + 1;

    logic              push_fire, pop_fire, head_take;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [LANE_W-1:0] ram_rd, out_lane;

    psf_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (s_tvalid),
        .pop_take  (head_take),
        .push_ok   (s_tready),
        .push_fire (push_fire),
        .pop_fire  (pop_fire),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr)
    );

    psf_ram #(.WIDTH(LANE_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .wr_en   (push_fire),
        .wr_addr (wr_addr),
        .wr_data ({s_tlast, s_tdata}),
        .rd_en   (head_take),
        .rd_addr (rd_addr),
        .rd_data (ram_rd)
    );

    psf_out_pipe #(.WIDTH(LANE_W), .OUT_REGS(OUT_REGS)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_fire (pop_fire),
        .head_data (ram_rd),
        .head_take (head_take),
        .out_valid (m_tvalid),
        .out_data  (out_lane),
        .out_ready (m_tready)
    );

    assign m_tlast = out_lane[LANE_W-1];
    assign m_tdata = out_lane[DATA_W-1:0];

    initial begin
        if (OUT_REGS < int'(MIN_OUT_REGS))
            $error("OUT_REGS below minimum");
    end

    // R4: input ready moves only when a pointer moves
    a_r4_ready_from_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(wr_addr) && $stable(rd_addr) && !$past(push_fire) && !$past(pop_fire))
        |-> $stable(s_tready));
endmodule

// File: tb/ptr_axis_fifo_bench.sv
module ptr_axis_fifo_bench;
    localparam int DATA_W = 8, ADDR_W = 4, OUT_REGS = 2;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CAP = DEPTH + OUT_REGS + 1;

    logic clk = 0, rst_n = 0;
    logic [DATA_W-1:0] s_tdata = '0;
    logic s_tlast = 0, s_tvalid = 0, m_tready = 0;
    logic s_tready, m_tlast, m_tvalid;
    logic [DATA_W-1:0] m_tdata;

    always #5 clk = ~clk;

    ptr_axis_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REGS(OUT_REGS)) u_ptr_axis_fifo (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready));

    int checks = 0, fails = 0, accepted = 0;
    logic [8:0] model_q [$];
    logic prev_mv = 0, prev_mr = 0, obs_mv = 0;
    logic [8:0] prev_lane = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: observe at the falling edge, then drive for the next rising edge.
    task automatic cyc(input logic sv, input logic [8:0] beat, input logic mr);
        logic [8:0] exp_lane;
        @(negedge clk);
        obs_mv = m_tvalid;
        if (prev_mv && !prev_mr) begin
            chk(m_tvalid == 1'b1, "R8 valid held", int'(m_tvalid), 1);
            chk({m_tlast, m_tdata} == prev_lane, "R8 beat held",
                int'({m_tlast, m_tdata}), int'(prev_lane));
        end
        if (!s_tready)
            chk(model_q.size() >= DEPTH, "R4 ready low only with RAM full",
                model_q.size(), DEPTH);
        s_tvalid = sv;
        {s_tlast, s_tdata} = beat;
        m_tready = mr;
        if (sv && s_tready) begin
            model_q.push_back(beat);
            accepted++;
        end
        if (m_tvalid && mr) begin
            if (model_q.size() == 0)
                chk(1'b0, "R3 unexpected beat", int'({m_tlast, m_tdata}), -1);
            else begin
                exp_lane = model_q.pop_front();
                chk(m_tdata == exp_lane[7:0], "R3 order", int'(m_tdata), int'(exp_lane[7:0]));
                chk(m_tlast == exp_lane[8], "R9 last flag", int'(m_tlast), int'(exp_lane[8]));
            end
        end
        prev_mv = m_tvalid;
        prev_mr = mr;
        prev_lane = {m_tlast, m_tdata};
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cyc(0, '0, 0);
        chk(s_tready == 1'b1, "R1 ready after reset", int'(s_tready), 1);
        chk(m_tvalid == 1'b0, "R1 no valid after reset", int'(m_tvalid), 0);

        // R6: latency from empty
        cyc(1, 9'h1A5, 0);
        for (int k = 1; k <= OUT_REGS + 2; k++) begin
            cyc(0, '0, 0);
            chk(obs_mv == (k >= OUT_REGS + 2), "R6 first valid timing",
                int'(obs_mv), int'(k >= OUT_REGS + 2));
        end
        // R2: stalled beat not consumed, then exactly one taken
        cyc(0, '0, 0);
        cyc(0, '0, 1);
        cyc(0, '0, 0);
        chk(obs_mv == 1'b0, "R2 one beat per handshake", int'(obs_mv), 0);
        chk(model_q.size() == 0, "R2 model empty", model_q.size(), 0);

        // R4/R5: capacity with output stalled
        accepted = 0;
        for (int i = 0; i < 60; i++)
            cyc(1, {i[0], 8'(i + 16)}, 0);
        cyc(0, '0, 0);
        chk(accepted == CAP, "R4 capacity", accepted, CAP);
        chk(s_tready == 1'b0, "R5 ready low when full", int'(s_tready), 0);

        // R7: gap-free drain
        begin
            int run = 0;
            bit ended = 0;
            for (int i = 0; i < CAP + 4; i++) begin
                cyc(0, '0, 1);
                if (!ended && obs_mv) run++;
                else ended = 1;
            end
            chk(run == CAP, "R7 consecutive output run", run, CAP);
            chk(model_q.size() == 0, "R5 no extra beats delivered", model_q.size(), 0);
        end

        // R3/R9: random handshakes
        for (int i = 0; i < 4000; i++)
            cyc(1'($urandom % 3 != 0), 9'($urandom), 1'($urandom % 2));
        for (int i = 0; i < 60; i++)
            cyc(0, '0, 1);
        chk(model_q.size() == 0, "R3 all beats delivered", model_q.size(), 0);
        chk(m_tvalid == 1'b0 && s_tready == 1'b1, "R1 idle after drain",
            int'({m_tvalid, s_tready}), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule